// File: doc/BRIEF.md
# Packed 16-bit Multiply and Shift Unit

This block multiplies two 64-bit operands that are each viewed as four 16-bit lanes. Two widening modes pick either the even lanes (0 and 2) or the odd lanes (1 and 3). Each widening mode multiplies the chosen lane pairs as signed values and returns two full 32-bit products. A third, narrowing mode multiplies all four lane pairs and shifts each 32-bit product right by one of four fixed amounts. It then keeps the low 16 bits of each shifted product in the matching result lane. The narrowing mode has a signed form and an unsigned form.

A request is presented with `in_valid` high, together with the mode, the form select, the shift code and both operands. The products are formed in one combinational stage, and the answer is captured in a single result register. It appears one cycle later with `out_valid` high.

A two-state controller tracks whether the register holds a fresh answer:
- `ST_EMPTY` moves to `ST_LOADED` on an accepted request, and otherwise stays in `ST_EMPTY`.
- `ST_LOADED` stays in `ST_LOADED` on another accepted request, and otherwise returns to `ST_EMPTY`.

`out_valid` is high exactly in `ST_LOADED`.

Top module: `simd_mulshift`

## Requirements
- R1: After reset, `out_valid` is 0 and `result` is all zeros.
- R2: In mode 2'b00 (even lanes), `result[31:0]` is the signed 32-bit product of lane 0 of both operands, and `result[63:32]` is the signed product of lane 2. Lane i occupies bits 16i+15:16i.
- R3: In mode 2'b01 (odd lanes), `result[31:0]` is the signed product of lane 1, and `result[63:32]` is the signed product of lane 3.
- R4: In mode 2'b10 (narrowing), each 32-bit lane product is shifted right, and its low 16 bits are written to the same lane position of `result`.
- R5: In the narrowing mode the shift code selects the amount: 2'b00 gives 0, 2'b01 gives 7, 2'b10 gives 15 and 2'b11 gives 16 bits.
- R6: With `unsigned_sel` = 0 the narrowing mode treats lanes as signed and shifts arithmetically.
- R7: With `unsigned_sel` = 1 the narrowing mode treats lanes as unsigned and shifts logically.
- R8: `unsigned_sel` and `shift_code` have no effect in the two widening modes.
- R9: A request accepted at a clock edge (`in_valid` = 1 and mode not 2'b11) makes `result` and `out_valid` = 1 visible right after that edge. Back-to-back requests each produce a result on consecutive cycles.
- R10: At an edge where `in_valid` = 0, or where mode is 2'b11, nothing is accepted. `result` keeps its value and `out_valid` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | 00 even widen, 01 odd widen, 10 narrow, 11 not accepted |
| unsigned_sel | input | 1 | Narrowing form: 0 signed, 1 unsigned |
| shift_code | input | 2 | Narrowing shift amount code |
| opa | input | 64 | First operand, four 16-bit lanes |
| opb | input | 64 | Second operand, four 16-bit lanes |
| out_valid | output | 1 | Result register holds the answer to the last cycle's request |
| result | output | 64 | Registered result |

## Verification
The controller's only state is whether the register was just loaded. A wrong state or a wrong load enable therefore shows at the ports one cycle after the request that exposes it. It appears either as an `out_valid` level that disagrees with the previous cycle's accept, or as a `result` that changed although nothing was accepted. A wrong lane pairing, sign treatment or shift amount appears in the very next result. This is why the vectors mix negative extremes, all-ones lanes and every shift code in both forms.

// File: rtl/simd_ms_pkg.sv
`timescale 1ns/1ps
package simd_ms_pkg;
    typedef enum logic [1:0] {
        MODE_EVEN   = 2'b00,
        MODE_ODD    = 2'b01,
        MODE_NARROW = 2'b10,
        MODE_RSVD   = 2'b11
    } op_mode_e;

    typedef enum logic {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/simd_ms_lane_mul.sv
`timescale 1ns/1ps
module simd_ms_lane_mul #(
    parameter int W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           is_signed,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] a_s, b_s, p_s;
    logic        [PW-1:0] a_u, b_u, p_u;

    always_comb begin
        a_s = $signed({{W{a[W-1]}}, a});
        b_s = $signed({{W{b[W-1]}}, b});
        a_u = {{W{1'b0}}, a};
        b_u = {{W{1'b0}}, b};
        p_s = a_s * b_s;
        p_u = a_u * b_u;
        prod = is_signed ? p_s : p_u;
    end
endmodule

// File: rtl/simd_ms_narrow.sv
`timescale 1ns/1ps
module simd_ms_narrow #(
    parameter int W   = 16,
    parameter int SH0 = 0,
    parameter int SH1 = 7,
    parameter int SH2 = 15,
    parameter int SH3 = 16
) (
    input  logic [2*W-1:0] prod,
    input  logic [1:0]     code,
    input  logic           arith,
    output logic [W-1:0]   lane_out
);
    localparam int EW = 3 * W;
    localparam int AW = $clog2(EW + 1);

    logic [EW-1:0] ext;
    logic [AW-1:0] amt;

    always_comb begin
        unique case (code)
            2'b00: amt = AW'(SH0);
            2'b01: amt = AW'(SH1);
            2'b10: amt = AW'(SH2);
            2'b11: amt = AW'(SH3);
        endcase
        ext      = {{W{arith & prod[2*W-1]}}, prod};
        lane_out = ext[amt +: W];
    end
endmodule

// File: rtl/simd_ms_pack.sv
`timescale 1ns/1ps
module simd_ms_pack
    import simd_ms_pkg::*;
#(
    parameter int W     = 16,
    parameter int LANES = 4
) (
    input  logic [1:0]                   mode,
    input  logic [LANES-1:0][2*W-1:0]    prod,
    input  logic [LANES-1:0][W-1:0]      nar,
    output logic [LANES*W-1:0]           packed_out
);
    localparam int PAIRS = LANES / 2;

    logic [LANES*W-1:0] wide_v, narrow_v;
    logic               pick_odd;

    assign pick_odd = (mode == MODE_ODD);

    for (genvar k = 0; k < PAIRS; k++) begin : g_wide
        assign wide_v[k*2*W +: 2*W] = pick_odd ? prod[2*k+1] : prod[2*k];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_nar
        assign narrow_v[i*W +: W] = nar[i];
    end

    assign packed_out = (mode == MODE_NARROW) ? narrow_v : wide_v;
endmodule

// File: rtl/simd_ms_ctrl.sv
`timescale 1ns/1ps
module simd_ms_ctrl
    import simd_ms_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [1:0] mode,
    output logic       load_en,
    output logic       out_valid
);
    ctl_state_e state_q, state_d;
    logic       accept;

    assign accept = in_valid && (mode != MODE_RSVD);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_EMPTY:  state_d = accept ? ST_LOADED : ST_EMPTY;
            ST_LOADED: state_d = accept ? ST_LOADED : ST_EMPTY;
        endcase
    end

    always_comb begin
        out_valid = (state_q == ST_LOADED);
        load_en   = accept;
    end

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode != MODE_RSVD) |=> out_valid);

    assert_valid_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && mode != MODE_RSVD) |=> !out_valid);
endmodule

// File: rtl/simd_mulshift.sv
`timescale 1ns/1ps
module simd_mulshift
    import simd_ms_pkg::*;
#(
    parameter int W     = 16,
    parameter int LANES = 4,
    parameter int SH0   = 0,
    parameter int SH1   = 7,
    parameter int SH2   = 15,
    parameter int SH3   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [1:0]           mode,
    input  logic                 unsigned_sel,
    input  logic [1:0]           shift_code,
    input  logic [LANES*W-1:0]   opa,
    input  logic [LANES*W-1:0]   opb,
    output logic                 out_valid,
    output logic [LANES*W-1:0]   result
);
    localparam int DW = LANES * W;

    logic [LANES-1:0][2*W-1:0] prod;
    logic [LANES-1:0][W-1:0]   nar;
    logic [DW-1:0]             result_d;
    logic                      load_en;
    logic                      mul_signed;
    logic                      arith;

    // widening modes are always signed; the form select only steers narrowing
    assign mul_signed = (mode != MODE_NARROW) || !unsigned_sel;
    assign arith      = !unsigned_sel;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        simd_ms_lane_mul #(.W(W)) u_mul (
            .a         (opa[i*W +: W]),
            .b         (opb[i*W +: W]),
            .is_signed (mul_signed),
            .prod      (prod[i])
        );
        simd_ms_narrow #(.W(W), .SH0(SH0), .SH1(SH1), .SH2(SH2), .SH3(SH3)) u_nar (
            .prod     (prod[i]),
            .code     (shift_code),
            .arith    (arith),
            .lane_out (nar[i])
        );
    end

    simd_ms_pack #(.W(W), .LANES(LANES)) u_pack (
        .mode       (mode),
        .prod       (prod),
        .nar        (nar),
        .packed_out (result_d)
    );

    simd_ms_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .mode      (mode),
        .load_en   (load_en),
        .out_valid (out_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       result <= '0;
        else if (load_en) result <= result_d;
    end

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(result));

    // a nonzero signed product of two nonzero lanes carries the XOR of their signs
    assert_even_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MODE_EVEN && opa[W-1:0] != '0 && opb[W-1:0] != '0)
        |=> result[2*W-1] == $past(opa[W-1] ^ opb[W-1]));
endmodule

// File: tb/simd_mulshift_test.sv
`timescale 1ns/1ps
module simd_mulshift_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        unsigned_sel = 1'b0;
    logic [1:0]  shift_code = 2'b00;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    simd_mulshift uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .unsigned_sel(unsigned_sel), .shift_code(shift_code),
        .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
    );

    typedef struct packed {
        logic [1:0]  m;
        logic        us;
        logic [1:0]  sc;
        logic [63:0] a;
        logic [63:0] b;
    } vec_t;

    localparam vec_t [0:9] VECS = '{
        '{2'b00, 1'b0, 2'b00, 64'h0003_7FFF_0005_8000, 64'h0004_8000_0006_8000},
        '{2'b01, 1'b0, 2'b00, 64'hFFFF_1234_8000_0001, 64'h0002_0001_7FFF_FFFF},
        '{2'b10, 1'b0, 2'b00, 64'h1234_FFFF_8000_0003, 64'h0010_0002_8000_FFFD},
        '{2'b10, 1'b0, 2'b01, 64'h1234_FFFF_8000_0003, 64'h0010_0002_8000_FFFD},
        '{2'b10, 1'b0, 2'b10, 64'h7FFF_FFFF_8000_0100, 64'h7FFF_0002_8000_FF00},
        '{2'b10, 1'b0, 2'b11, 64'h7FFF_FFFF_8000_0100, 64'h7FFF_0002_8000_FF00},
        '{2'b10, 1'b1, 2'b00, 64'h1234_FFFF_8000_0003, 64'h0010_0002_8000_FFFD},
        '{2'b10, 1'b1, 2'b01, 64'h1234_FFFF_8000_0003, 64'h0010_0002_8000_FFFD},
        '{2'b10, 1'b1, 2'b10, 64'hFFFF_FFFF_8000_0100, 64'hFFFF_0002_8000_FF00},
        '{2'b10, 1'b1, 2'b11, 64'hFFFF_FFFF_8000_0100, 64'hFFFF_0002_8000_FF00}
    };

    function automatic logic [63:0] model(input logic [1:0] m, input logic us,
                                          input logic [1:0] sc,
                                          input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r = '0;
        int amt;
        case (sc)
            2'b00: amt = 0;
            2'b01: amt = 7;
            2'b10: amt = 15;
            default: amt = 16;
        endcase
        if (m == 2'b10) begin
            for (int i = 0; i < 4; i++) begin
                longint pa, pb, p;
                if (us) begin
                    pa = longint'({48'b0, a[16*i +: 16]});
                    pb = longint'({48'b0, b[16*i +: 16]});
                end else begin
                    pa = longint'($signed(a[16*i +: 16]));
                    pb = longint'($signed(b[16*i +: 16]));
                end
                p = (pa * pb) >>> amt;
                r[16*i +: 16] = p[15:0];
            end
        end else begin
            for (int k = 0; k < 2; k++) begin
                longint p;
                int idx = 2*k + int'(m[0]);
                p = longint'($signed(a[16*idx +: 16])) * longint'($signed(b[16*idx +: 16]));
                r[32*k +: 32] = p[31:0];
            end
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [1:0] m, input logic us);
        if (m == 2'b00) return "R2";
        if (m == 2'b01) return "R3";
        return us ? "R4/R5/R7" : "R4/R5/R6";
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] m, input logic us,
                         input logic [1:0] sc, input logic [63:0] a, input logic [63:0] b);
        in_valid = v; mode = m; unsigned_sel = us; shift_code = sc; opa = a; opb = b;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 out_valid", {63'b0, out_valid}, 64'd0);
        chk("R1 result", result, 64'd0);
        rst_n = 1'b1;

        // table walk, back-to-back requests (R9)
        for (int n = 0; n < 10; n++) begin
            drive(1'b1, VECS[n].m, VECS[n].us, VECS[n].sc, VECS[n].a, VECS[n].b);
            @(negedge clk);
            chk("R9 out_valid", {63'b0, out_valid}, 64'd1);
            chk(tag_of(VECS[n].m, VECS[n].us), result,
                model(VECS[n].m, VECS[n].us, VECS[n].sc, VECS[n].a, VECS[n].b));
        end

        // R2 extremes: (-32768)^2 and 32767*(-32768)
        drive(1'b1, 2'b00, 1'b0, 2'b00, 64'h0000_7FFF_0000_8000, 64'h0000_8000_0000_8000);
        @(negedge clk);
        chk("R2 extremes", result, 64'hC000_8000_4000_0000);

        // R3 odd lanes: lane1 = -1*2, lane3 = 3*3
        drive(1'b1, 2'b01, 1'b0, 2'b00, 64'h0003_0000_FFFF_0000, 64'h0003_0000_0002_0000);
        @(negedge clk);
        chk("R3 odd lanes", result, 64'h0000_0009_FFFF_FFFE);

        // R8 form select and shift code ignored in widening mode
        drive(1'b1, 2'b00, 1'b1, 2'b11, 64'h0000_7FFF_0000_8000, 64'h0000_8000_0000_8000);
        @(negedge clk);
        chk("R8 ignored controls", result, 64'hC000_8000_4000_0000);

        // R6 signed: lane0 -1*-1 >>>16 = 0, lane1 -1*2 >>>7 = FFFF
        drive(1'b1, 2'b10, 1'b0, 2'b11, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_FFFF);
        @(negedge clk);
        chk("R6 signed shift16", result, 64'h0000_0000_0000_0000);
        drive(1'b1, 2'b10, 1'b0, 2'b01, 64'h0000_0000_FFFF_0000, 64'h0000_0000_0002_0000);
        @(negedge clk);
        chk("R6 arithmetic shift7", result, 64'h0000_0000_FFFF_0000);

        // R7 unsigned: FFFF*FFFF >>16 = FFFE, FFFF*2 >>7 = 03FF
        drive(1'b1, 2'b10, 1'b1, 2'b11, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_FFFF);
        @(negedge clk);
        chk("R7 unsigned shift16", result, 64'h0000_0000_0000_FFFE);
        drive(1'b1, 2'b10, 1'b1, 2'b01, 64'h0000_0000_FFFF_0000, 64'h0000_0000_0002_0000);
        @(negedge clk);
        chk("R7 logical shift7", result, 64'h0000_0000_03FF_0000);

        // R5 shift 15: (-32768)^2 >>>15 = 8000
        drive(1'b1, 2'b10, 1'b0, 2'b10, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_8000);
        @(negedge clk);
        chk("R5 shift15", result, 64'h0000_0000_0000_8000);
        held = result;

        // R10 no request: result holds, out_valid low
        drive(1'b0, 2'b00, 1'b0, 2'b00, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
        @(negedge clk);
        chk("R10 idle out_valid", {63'b0, out_valid}, 64'd0);
        chk("R10 idle hold", result, held);

        // R10 mode 11 with strobe: not accepted
        drive(1'b1, 2'b11, 1'b0, 2'b00, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888);
        @(negedge clk);
        chk("R10 rsvd out_valid", {63'b0, out_valid}, 64'd0);
        chk("R10 rsvd hold", result, held);

        // R9 recovery after a gap
        drive(1'b1, 2'b00, 1'b0, 2'b00, 64'h0000_0002_0000_0003, 64'h0000_0004_0000_0005);
        @(negedge clk);
        chk("R9 after gap valid", {63'b0, out_valid}, 64'd1);
        chk("R9 after gap result", result, 64'h0000_0008_0000_000F);
        drive(1'b0, 2'b00, 1'b0, 2'b00, '0, '0);

        // R1 reset again clears state
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 re-reset valid", {63'b0, out_valid}, 64'd0);
        chk("R1 re-reset result", result, 64'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule